// File: doc/BRIEF.md
# Indexed postbyte address generator

This block turns a one-byte indexed-addressing postbyte, plus up to two extension bytes, into a 16-bit effective address. The caller presents the postbyte, both candidate extension bytes, the four base registers (X, Y, SP and PC) and the two 8-bit accumulators, then pulses `start_i`. The block captures everything on that edge. It decodes one of five postbyte formats and adds the selected offset to the selected base register. For the two indirect formats it also fetches a 16-bit pointer through a simple request/acknowledge read port. It ends with a one-cycle `done_o` pulse.

With the result the block reports three more things. It reports how many extension bytes the postbyte used, so the caller can advance its fetch pointer. It reports how many extra cycles the addressing mode costs. For the auto-modify formats it also reports a base-register write-back: which register, and its new value. The block does not fetch opcodes and does not perform the final operand access.

The 16-bit accumulator D is the concatenation {A, B}. The value of `pc_i` is the address of the byte that follows the postbyte.

Top module: `idx_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `busy_o`, `rd_req_o` and `wb_en_o` are 0.
- R2: A postbyte with bit 5 = 0 adds the two's-complement value of bits 4:0 to the base register chosen by bits 7:6. The base codes are 0 = X, 1 = Y, 2 = SP and 3 = PC. This format uses no extension byte and costs no extra cycle.
- R3: A postbyte with bit 5 = 1 and bits 7:6 other than 3 is auto-modify on the register in bits 7:6. Step field bits 3:0 values 0..7 mean +1..+8, and values 8..15 mean -8..-1. With `done_o`, `wb_en_o` is 1, `wb_sel_o` carries the base code and `wb_val_o` carries the old value plus the step. `wb_en_o` is 0 for every other format.
- R4: In auto-modify, bit 4 = 0 makes the effective address the updated register value (pre-modify), and bit 4 = 1 makes it the original value (post-modify).
- R5: Bits 7:5 = 111 with bits 2:1 = 00 selects the register in bits 4:3 plus a 9-bit signed offset. Bit 0 is the sign and `ext0_i` holds the low 8 bits. `ext_cnt_o` = 1 and `extra_o` = 0.
- R6: Bits 7:5 = 111 with bits 2:1 = 01 adds the 16-bit offset {`ext0_i`, `ext1_i`} (first byte high) to the register in bits 4:3. `ext_cnt_o` = 2 and `extra_o` = 1.
- R7: Bits 7:5 = 111 with bit 2 = 1 adds an accumulator to the register in bits 4:3. Bits 1:0 select the accumulator: 0 = A or 1 = B, each zero-extended, or 2 = D. `ext_cnt_o` = 0 and `extra_o` = 0.
- R8: Bits 7:5 = 111 with bits 2:0 = 011 (16-bit offset) or bits 2:0 = 111 (D) computes a pointer address, reads a 16-bit word there, and returns that word as `ea_o`, with `extra_o` = 1. `ext_cnt_o` is 2 and 0 respectively.
- R9: During an indirect read, `rd_req_o` stays high with `rd_addr_o` unchanged until `rd_ack_i` is sampled high. `done_o` pulses for one cycle on the next rising edge.
- R10: When the base code is PC, the base value is `pc_i` plus the number of extension bytes the postbyte uses.
- R11: All address and write-back arithmetic wraps modulo 2^16.
- R12: A `start_i` while `busy_o` is high is ignored and does not alter the operation in progress.
- R13: For formats without a memory read, `done_o` pulses on the second rising edge after the edge that accepts `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin decoding the presented postbyte |
| pb_i | input | 8 | Indexed postbyte |
| ext0_i | input | 8 | First extension byte |
| ext1_i | input | 8 | Second extension byte |
| x_i | input | 16 | Index register X |
| y_i | input | 16 | Index register Y |
| sp_i | input | 16 | Stack pointer |
| pc_i | input | 16 | Address of the byte after the postbyte |
| acc_a_i | input | 8 | Accumulator A (high half of D) |
| acc_b_i | input | 8 | Accumulator B (low half of D) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | 16 | Effective address |
| wb_en_o | output | 1 | Base-register write-back valid (with done) |
| wb_sel_o | output | 2 | Base code of the register to write back |
| wb_val_o | output | 16 | Write-back value |
| ext_cnt_o | output | 2 | Extension bytes used by the postbyte |
| extra_o | output | 2 | Extra cycles the mode costs |
| rd_req_o | output | 1 | Indirect pointer read request |
| rd_addr_o | output | 16 | Pointer read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 16 | Pointer word returned |

## Verification
The decoder is driven with one postbyte from each format and with every base code, including PC. The PC cases show whether the extension-byte count enters the base value. Positive and negative short constants, 9-bit offsets with either sign bit, and the step extremes +8, +4, +1, -1 and -8 in both pre and post form separate sign-extension errors from field-position errors. Accumulator B is chosen above 0x7F so that zero- and sign-extension give different sums. The indirect cases return data that differs from the pointer address, acknowledge after zero or several wait cycles, and inject a second start mid-read. A sum that crosses 0xFFFF and an auto-increment from 0xFFFF exercise the wrap.

// File: rtl/idx_pkg.sv
package idx_pkg;

  localparam int PB_W  = 8;
  localparam int EXT_W = 8;

  typedef enum logic [2:0] {
    MD_CONST5 = 3'd0,
    MD_AUTO   = 3'd1,
    MD_OFF9   = 3'd2,
    MD_OFF16  = 3'd3,
    MD_IND16  = 3'd4,
    MD_ACC    = 3'd5,
    MD_ACCIND = 3'd6
  } idx_mode_e;

  typedef enum logic [1:0] {
    BR_X  = 2'd0,
    BR_Y  = 2'd1,
    BR_SP = 2'd2,
    BR_PC = 2'd3
  } base_reg_e;

  typedef enum logic [1:0] {
    AC_A    = 2'd0,
    AC_B    = 2'd1,
    AC_D    = 2'd2,
    AC_DIND = 2'd3
  } acc_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_READ = 2'd2
  } seq_st_e;

  typedef struct packed {
    idx_mode_e mode;
    base_reg_e base;
    logic      post;
    acc_sel_e  acc;
    logic [1:0] ext_len;
    logic      indirect;
    logic      extra;
  } idx_dec_t;

endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [PB_W-1:0]  pb_i,
  input  logic [EXT_W-1:0] ext0_i,
  input  logic [EXT_W-1:0] ext1_i,
  output idx_dec_t         dec_o,
  output logic [AW-1:0]    off_o
);

  always_comb begin
    dec_o     = '0;
    off_o     = '0;
    dec_o.base = base_reg_e'(pb_i[7:6]);
    if (!pb_i[5]) begin
      // short signed constant in the postbyte itself
      dec_o.mode = MD_CONST5;
      off_o      = AW'($signed(pb_i[4:0]));
    end else if (pb_i[7:6] != 2'b11) begin
      // auto pre/post modify, step has no zero value
      dec_o.mode = MD_AUTO;
      dec_o.post = pb_i[4];
      if (pb_i[3]) off_o = AW'($signed(pb_i[3:0]));
      else         off_o = AW'({1'b0, pb_i[3:0]} + 5'd1);
    end else begin
      dec_o.base = base_reg_e'(pb_i[4:3]);
      if (pb_i[2:0] == 3'b011) begin
        dec_o.mode     = MD_IND16;
        off_o          = AW'({ext0_i, ext1_i});
        dec_o.ext_len  = 2'd2;
        dec_o.indirect = 1'b1;
        dec_o.extra    = 1'b1;
      end else if (!pb_i[2]) begin
        if (pb_i[1]) begin
          dec_o.mode    = MD_OFF16;
          off_o         = AW'({ext0_i, ext1_i});
          dec_o.ext_len = 2'd2;
          dec_o.extra   = 1'b1;
        end else begin
          dec_o.mode    = MD_OFF9;
          off_o         = AW'($signed({pb_i[0], ext0_i}));
          dec_o.ext_len = 2'd1;
        end
      end else begin
        dec_o.acc = acc_sel_e'(pb_i[1:0]);
        if (pb_i[1:0] == 2'b11) begin
          dec_o.mode     = MD_ACCIND;
          dec_o.indirect = 1'b1;
          dec_o.extra    = 1'b1;
        end else begin
          dec_o.mode = MD_ACC;
        end
      end
    end
  end

endmodule

// File: rtl/idx_calc.sv
module idx_calc
  import idx_pkg::*;
#(
  parameter int AW = 16
) (
  input  idx_dec_t         dec_i,
  input  logic [AW-1:0]    off_i,
  input  logic [AW-1:0]    x_i,
  input  logic [AW-1:0]    y_i,
  input  logic [AW-1:0]    sp_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [EXT_W-1:0] acc_a_i,
  input  logic [EXT_W-1:0] acc_b_i,
  output logic [AW-1:0]    sum_o,
  output logic [AW-1:0]    ea_o
);

  localparam int NBASE = 4;

  logic [AW-1:0] base_bank [NBASE];
  logic [AW-1:0] base_val;
  logic [AW-1:0] addend;

  // PC-relative base points past every extension byte of the postbyte
  assign base_bank[BR_X]  = x_i;
  assign base_bank[BR_Y]  = y_i;
  assign base_bank[BR_SP] = sp_i;
  assign base_bank[BR_PC] = pc_i + AW'(dec_i.ext_len);

  assign base_val = base_bank[dec_i.base];

  always_comb begin
    addend = off_i;
    if (dec_i.mode == MD_ACC || dec_i.mode == MD_ACCIND) begin
      unique case (dec_i.acc)
        AC_A:    addend = AW'(acc_a_i);
        AC_B:    addend = AW'(acc_b_i);
        default: addend = AW'({acc_a_i, acc_b_i});
      endcase
    end
  end

  assign sum_o = base_val + addend;
  assign ea_o  = (dec_i.mode == MD_AUTO && dec_i.post) ? base_val : sum_o;

endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          need_rd_i,
  input  logic [AW-1:0] ptr_addr_i,
  input  logic          rd_ack_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          take_dir_o,
  output logic          take_rd_o,
  output logic          done_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);

  seq_st_e       state_q, state_d;
  logic          done_q, done_d;
  logic [AW-1:0] addr_q;
  logic          addr_en;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    take_dir_o = 1'b0;
    take_rd_o  = 1'b0;
    addr_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        if (need_rd_i) begin
          addr_en = 1'b1;
          state_d = ST_READ;
        end else begin
          take_dir_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_READ: begin
        if (rd_ack_i) begin
          take_rd_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = take_dir_o | take_rd_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (addr_en) addr_q <= ptr_addr_i;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rd_req_o  = (state_q == ST_READ);
  assign rd_addr_o = addr_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o); // R9

endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    pb_i,
  input  logic [7:0]    ext0_i,
  input  logic [7:0]    ext1_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [7:0]    acc_a_i,
  input  logic [7:0]    acc_b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic          wb_en_o,
  output logic [1:0]    wb_sel_o,
  output logic [AW-1:0] wb_val_o,
  output logic [1:0]    ext_cnt_o,
  output logic [1:0]    extra_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [AW-1:0] rd_data_i
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  // captured operands
  logic [7:0]    pb_q, e0_q, e1_q, a_q, b_q;
  logic [AW-1:0] x_q, y_q, sp_q, pc_q;
  logic          load;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pb_q <= '0; e0_q <= '0; e1_q <= '0; a_q <= '0; b_q <= '0;
      x_q  <= '0; y_q  <= '0; sp_q <= '0; pc_q <= '0;
    end else if (load) begin
      pb_q <= pb_i; e0_q <= ext0_i; e1_q <= ext1_i;
      a_q  <= acc_a_i; b_q <= acc_b_i;
      x_q  <= x_i; y_q <= y_i; sp_q <= sp_i; pc_q <= pc_i;
    end
  end

  idx_dec_t      dec;
  logic [AW-1:0] off, sum, ea_dir;
  logic          take_dir, take_rd;

  idx_decode #(.AW(AW)) u_dec (
    .pb_i   (pb_q),
    .ext0_i (e0_q),
    .ext1_i (e1_q),
    .dec_o  (dec),
    .off_o  (off)
  );

  idx_calc #(.AW(AW)) u_calc (
    .dec_i   (dec),
    .off_i   (off),
    .x_i     (x_q),
    .y_i     (y_q),
    .sp_i    (sp_q),
    .pc_i    (pc_q),
    .acc_a_i (a_q),
    .acc_b_i (b_q),
    .sum_o   (sum),
    .ea_o    (ea_dir)
  );

  idx_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .need_rd_i  (dec.indirect),
    .ptr_addr_i (sum),
    .rd_ack_i   (rd_ack_i),
    .busy_o     (busy_o),
    .load_o     (load),
    .take_dir_o (take_dir),
    .take_rd_o  (take_rd),
    .done_o     (done_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o)
  );

  // result registers: next-state then flops
  logic [AW-1:0] ea_q, ea_d, wbv_q, wbv_d;
  logic          wbe_q, wbe_d, res_en;
  logic [1:0]    wbs_q, wbs_d, ext_q, ext_d, xtr_q, xtr_d;

  always_comb begin
    res_en = take_dir | take_rd;
    ea_d   = take_rd ? rd_data_i : ea_dir;
    wbe_d  = res_en && (dec.mode == MD_AUTO);
    wbs_d  = dec.base;
    wbv_d  = sum;
    ext_d  = dec.ext_len;
    xtr_d  = {1'b0, dec.extra};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ea_q  <= '0; wbv_q <= '0; wbe_q <= 1'b0;
      wbs_q <= '0; ext_q <= '0; xtr_q <= '0;
    end else begin
      wbe_q <= wbe_d;
      if (res_en) begin
        ea_q  <= ea_d;
        wbv_q <= wbv_d;
        wbs_q <= wbs_d;
        ext_q <= ext_d;
        xtr_q <= xtr_d;
      end
    end
  end

  assign ea_o      = ea_q;
  assign wb_en_o   = wbe_q;
  assign wb_sel_o  = wbs_q;
  assign wb_val_o  = wbv_q;
  assign ext_cnt_o = ext_q;
  assign extra_o   = xtr_q;

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    wb_en_o |-> done_o); // R3

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |=> $stable(pb_q)); // R12

  AST_IND_EXTRA: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o && $past(rd_req_o) |-> extra_o == 2'd1); // R8

endmodule

// File: tb/sim_idx_addr_gen.sv
module sim_idx_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    pb_i = '0, ext0_i = '0, ext1_i = '0, acc_a_i = '0, acc_b_i = '0;
  logic [AW-1:0] x_i = '0, y_i = '0, sp_i = '0, pc_i = '0;
  logic          busy_o, done_o, wb_en_o, rd_req_o;
  logic [AW-1:0] ea_o, wb_val_o, rd_addr_o;
  logic [1:0]    wb_sel_o, ext_cnt_o, extra_o;
  logic          rd_ack_i = 1'b0;
  logic [AW-1:0] rd_data_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pb_i(pb_i),
    .ext0_i(ext0_i), .ext1_i(ext1_i), .x_i(x_i), .y_i(y_i), .sp_i(sp_i),
    .pc_i(pc_i), .acc_a_i(acc_a_i), .acc_b_i(acc_b_i), .busy_o(busy_o),
    .done_o(done_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o),
    .wb_val_o(wb_val_o), .ext_cnt_o(ext_cnt_o), .extra_o(extra_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i)
  );

  // results of the last operation
  int            got_lat;
  logic          got_req;
  logic [AW-1:0] got_req_addr;
  logic          req_moved;

  function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
    return a ^ 16'hA5C3;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_regs();
    x_i = 16'h1000; y_i = 16'h2000; sp_i = 16'h3FF0; pc_i = 16'h8000;
    acc_a_i = 8'h12; acc_b_i = 8'hF0;
  endtask

  task automatic run_op(input logic [7:0] pb, input logic [7:0] e0,
                        input logic [7:0] e1, input int ack_wait,
                        input bit poke);
    int waited;
    @(negedge clk);
    pb_i = pb; ext0_i = e0; ext1_i = e1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got_lat = 1; got_req = 1'b0; req_moved = 1'b0; waited = 0;
    got_req_addr = '0;
    while (!done_o && got_lat < 40) begin
      if (rd_req_o) begin
        if (!got_req) got_req_addr = rd_addr_o;
        else if (rd_addr_o !== got_req_addr) req_moved = 1'b1;
        got_req = 1'b1;
        if (waited >= ack_wait) begin
          rd_ack_i = 1'b1; rd_data_i = mem_word(rd_addr_o);
        end else begin
          waited++;
        end
        if (poke) begin
          start_i = 1'b1; pb_i = 8'h00; ext0_i = 8'h00; ext1_i = 8'h00;
        end
      end
      @(negedge clk);
      rd_ack_i = 1'b0; start_i = 1'b0;
      got_lat++;
    end
  endtask

  task automatic expect_direct(input string req, input logic [7:0] pb,
                               input logic [7:0] e0, input logic [7:0] e1,
                               input logic [AW-1:0] ea, input int ext,
                               input int xtr);
    run_op(pb, e0, e1, 0, 1'b0);
    chk(req, "ea", ea_o, ea);
    chk(req, "ext count", ext_cnt_o, ext);
    chk(req, "extra cycles", extra_o, xtr);
    chk("R3", "no write-back", wb_en_o, 0);
    chk("R13", "latency", got_lat, 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "done in reset", done_o, 0);
    chk("R1", "busy in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "rd_req after reset", rd_req_o, 0);
    chk("R1", "wb_en after reset", wb_en_o, 0);
  endtask

  task automatic t_const5();
    set_regs();
    expect_direct("R2", 8'h05, 8'h00, 8'h00, 16'h1005, 0, 0);
    expect_direct("R2", 8'h5F, 8'h00, 8'h00, 16'h1FFF, 0, 0);
    expect_direct("R2", 8'h90, 8'h00, 8'h00, 16'h3FE0, 0, 0);
    expect_direct("R10", 8'hC1, 8'h00, 8'h00, 16'h8001, 0, 0);
  endtask

  task automatic chk_auto(input string req, input logic [7:0] pb,
                          input logic [AW-1:0] ea, input logic [1:0] sel,
                          input logic [AW-1:0] wb);
    run_op(pb, 8'h00, 8'h00, 0, 1'b0);
    chk(req, "ea", ea_o, ea);
    chk("R3", "wb_en", wb_en_o, 1);
    chk("R3", "wb_sel", wb_sel_o, sel);
    chk("R3", "wb_val", wb_val_o, wb);
    chk("R3", "ext count", ext_cnt_o, 0);
  endtask

  task automatic t_auto();
    set_regs();
    chk_auto("R4", 8'h23, 16'h1004, 2'd0, 16'h1004);
    chk_auto("R4", 8'h7F, 16'h2000, 2'd1, 16'h1FFF);
    chk_auto("R4", 8'hA8, 16'h3FE8, 2'd2, 16'h3FE8);
    chk_auto("R4", 8'h37, 16'h1000, 2'd0, 16'h1008);
    @(negedge clk);
    chk("R3", "wb_en drops after done", wb_en_o, 0);
  endtask

  task automatic t_offsets();
    set_regs();
    expect_direct("R5", 8'hE0, 8'h34, 8'h00, 16'h1034, 1, 0);
    expect_direct("R5", 8'hE9, 8'hFE, 8'h00, 16'h1FFE, 1, 0);
    expect_direct("R10", 8'hF8, 8'h10, 8'h00, 16'h8011, 1, 0);
    expect_direct("R6", 8'hF2, 8'h01, 8'h00, 16'h40F0, 2, 1);
    expect_direct("R10", 8'hFA, 8'h12, 8'h34, 16'h9236, 2, 1);
  endtask

  task automatic t_acc();
    set_regs();
    expect_direct("R7", 8'hE4, 8'h00, 8'h00, 16'h1012, 0, 0);
    expect_direct("R7", 8'hED, 8'h00, 8'h00, 16'h20F0, 0, 0);
    expect_direct("R7", 8'hF6, 8'h00, 8'h00, 16'h52E0, 0, 0);
  endtask

  task automatic chk_ind(input string req, input logic [7:0] pb,
                         input logic [7:0] e0, input logic [7:0] e1,
                         input logic [AW-1:0] ptr, input int ext,
                         input int ack_wait, input bit poke);
    run_op(pb, e0, e1, ack_wait, poke);
    chk(req, "read issued", got_req, 1);
    chk(req, "pointer address", got_req_addr, ptr);
    chk(req, "ea from memory", ea_o, mem_word(ptr));
    chk(req, "extra cycles", extra_o, 1);
    chk(req, "ext count", ext_cnt_o, ext);
    chk("R9", "address stable", req_moved, 0);
    chk("R9", "latency", got_lat, 3 + ack_wait);
  endtask

  task automatic t_indirect();
    set_regs();
    chk_ind("R8", 8'hE3, 8'h00, 8'h20, 16'h1020, 2, 0, 1'b0);
    chk_ind("R8", 8'hEF, 8'h00, 8'h00, 16'h32F0, 0, 3, 1'b0);
    chk_ind("R10", 8'hFB, 8'h00, 8'h04, 16'h8006, 2, 1, 1'b0);
  endtask

  task automatic t_busy_start();
    set_regs();
    chk_ind("R12", 8'hEF, 8'h00, 8'h00, 16'h32F0, 0, 2, 1'b1);
    repeat (3) @(negedge clk);
    chk("R12", "no second done", done_o, 0);
    chk("R12", "idle after op", busy_o, 0);
    chk("R12", "result kept", ea_o, mem_word(16'h32F0));
  endtask

  task automatic t_wrap();
    set_regs();
    expect_direct("R11", 8'hE2, 8'hF0, 8'h00, 16'h0000, 2, 1);
    x_i = 16'hFFFF;
    chk_auto("R11", 8'h20, 16'h0000, 2'd0, 16'h0000);
    set_regs();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_const5();
    t_auto();
    t_offsets();
    t_acc();
    t_indirect();
    t_busy_start();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule